// File: doc/BRIEF.md
# Multi-Channel Level/Edge Trigger Matcher

This block watches a stream of 16-bit sample words and raises a one-cycle hit when a programmed trigger pattern is seen. Each channel can be given one of four conditions (input low, input high, rising edge, falling edge) using two bit-masks: a level-select mask and a polarity mask. A third mask chooses which channels take part at all, and a channel-active mask removes channels that are not being captured. Every participating condition must be met on the same sample for the hit to fire.

Edge conditions compare a sample with the previous valid sample taken since the matcher was last armed. Only one participating channel may hold an edge condition. When more than one does, a configuration-error output is raised and no hit is produced. The matcher is armed by a one-cycle pulse. It fires at most once per arming and then disarms. If no channel participates, the first valid sample after arming fires the hit.

Top module: `trig_match_top`

## Requirements
- R1: A channel's condition counts only when its bit is set in both `trig_en_i` and `chan_act_i`. The `lvl_sel_i` and `pol_i` bits of other channels have no effect on `hit_o` or `cfg_err_o`.
- R2: With the level bit at 1, polarity bit 0 means the condition "sample bit is 0" and polarity bit 1 means "sample bit is 1".
- R3: With the level bit at 0, polarity bit 0 means a rising edge (previous valid sample bit 0, current bit 1) and polarity bit 1 means a falling edge (1 then 0). Cycles without `sample_valid_i` in between do not count.
- R4: `hit_o` is set only when every participating condition holds on the same valid sample.
- R5: `cfg_err_o` is 1 exactly when more than one participating channel has its level bit at 0. While it is 1, no hit is produced.
- R6: The first valid sample after arming has no previous sample, so an edge condition cannot be met on it.
- R7: When no channel participates, `involved_o` is 0 and the first valid sample after arming fires the hit. Otherwise `involved_o` is 1.
- R8: `hit_o` goes high for exactly one cycle, in the cycle after the clock edge that takes the matching sample. The matcher then disarms, and later samples produce no hit until `arm_i` is pulsed again.
- R9: A cycle with `arm_i` high clears the sample history and arms the matcher. A sample that is valid in that same cycle is neither evaluated nor stored as history.
- R10: After reset, `hit_o` is 0 and the matcher is disarmed, so valid samples produce no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | One-cycle pulse that arms the matcher and clears the sample history |
| sample_i | input | 16 | Sample word |
| sample_valid_i | input | 1 | Marks `sample_i` as a new sample |
| trig_en_i | input | 16 | Channels that take part in the trigger |
| lvl_sel_i | input | 16 | 1 = level condition, 0 = edge condition |
| pol_i | input | 16 | 1 = high or falling, 0 = low or rising |
| chan_act_i | input | 16 | Channels being captured; inactive channels are ignored |
| hit_o | output | 1 | One-cycle trigger hit |
| cfg_err_o | output | 1 | More than one edge condition is programmed |
| involved_o | output | 1 | At least one channel takes part in the trigger |

## Verification
Two events can fall in the same cycle: an arm pulse and a valid sample. The bench drives both together and then checks that the sample neither fires the hit nor serves as the previous value for a later edge. The other such pairing is a configuration error together with a matching sample. The bench sets up two edge channels and gives the matching edge on both, and no hit may follow. A gap with non-valid samples between two valid ones must still show the edge between the two valid samples.

// File: rtl/trig_match_pkg.sv
package trig_match_pkg;

    // Condition kind, encoded as {level bit, polarity bit}.
    typedef enum logic [1:0] {
        COND_RISE = 2'b00,
        COND_FALL = 2'b01,
        COND_LOW  = 2'b10,
        COND_HIGH = 2'b11
    } cond_kind_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } arm_state_e;

    // Whether one channel's condition is met by the current sample bit.
    function automatic logic cond_met(input cond_kind_e kind,
                                      input logic prev_b,
                                      input logic cur_b,
                                      input logic have_prev);
        logic r;
        case (kind)
            COND_LOW:  r = ~cur_b;
            COND_HIGH: r = cur_b;
            COND_RISE: r = have_prev & ~prev_b & cur_b;
            default:   r = have_prev & prev_b & ~cur_b;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/trig_cond_decode.sv
module trig_cond_decode
    import trig_match_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic [NCH-1:0] sample_i,
    input  logic [NCH-1:0] prev_i,
    input  logic           have_prev_i,
    input  logic [NCH-1:0] trig_en_i,
    input  logic [NCH-1:0] lvl_sel_i,
    input  logic [NCH-1:0] pol_i,
    input  logic [NCH-1:0] chan_act_i,
    output logic           all_met_o,
    output logic           cfg_err_o,
    output logic           involved_o
);
    localparam int CW = $clog2(NCH + 1);

    logic [NCH-1:0] part;
    logic [NCH-1:0] met;
    logic [NCH-1:0] edge_sel;
    logic [CW-1:0]  edge_cnt;

    assign part     = trig_en_i & chan_act_i;
    assign edge_sel = part & ~lvl_sel_i;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        cond_kind_e kind;
        assign kind   = cond_kind_e'({lvl_sel_i[c], pol_i[c]});
        assign met[c] = ~part[c] | cond_met(kind, prev_i[c], sample_i[c], have_prev_i);
    end

    always_comb begin
        edge_cnt = '0;
        for (int i = 0; i < NCH; i++) begin
            edge_cnt = edge_cnt + CW'(edge_sel[i]);
        end
    end

    assign all_met_o  = &met;
    assign cfg_err_o  = (edge_cnt > CW'(1));
    assign involved_o = |part;
endmodule

// File: rtl/trig_history.sv
module trig_history #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clear_i,
    input  logic           take_i,
    input  logic [NCH-1:0] sample_i,
    output logic [NCH-1:0] prev_o,
    output logic           have_prev_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_o      <= '0;
            have_prev_o <= 1'b0;
        end else if (clear_i) begin
            have_prev_o <= 1'b0;
        end else if (take_i) begin
            prev_o      <= sample_i;
            have_prev_o <= 1'b1;
        end
    end
endmodule

// File: rtl/trig_arm_ctrl.sv
module trig_arm_ctrl
    import trig_match_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic sample_valid_i,
    input  logic all_met_i,
    input  logic cfg_err_i,
    output logic armed_o,
    output logic take_o,
    output logic hit_o
);
    arm_state_e state_q;
    logic       fire;

    assign armed_o = (state_q == ST_ARMED);
    assign take_o  = armed_o & sample_valid_i & ~arm_i;
    assign fire    = take_o & all_met_i & ~cfg_err_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            hit_o   <= 1'b0;
        end else begin
            hit_o <= fire;
            if (arm_i) begin
                state_q <= ST_ARMED;
            end else if (fire) begin
                state_q <= ST_IDLE;
            end
        end
    end
endmodule

// File: rtl/trig_match_top.sv
module trig_match_top
    import trig_match_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           arm_i,
    input  logic [NCH-1:0] sample_i,
    input  logic           sample_valid_i,
    input  logic [NCH-1:0] trig_en_i,
    input  logic [NCH-1:0] lvl_sel_i,
    input  logic [NCH-1:0] pol_i,
    input  logic [NCH-1:0] chan_act_i,
    output logic           hit_o,
    output logic           cfg_err_o,
    output logic           involved_o
);
    logic [NCH-1:0] prev;
    logic           have_prev;
    logic           all_met;
    logic           armed;
    logic           take;

    trig_cond_decode #(.NCH(NCH)) u_dec (
        .sample_i    (sample_i),
        .prev_i      (prev),
        .have_prev_i (have_prev),
        .trig_en_i   (trig_en_i),
        .lvl_sel_i   (lvl_sel_i),
        .pol_i       (pol_i),
        .chan_act_i  (chan_act_i),
        .all_met_o   (all_met),
        .cfg_err_o   (cfg_err_o),
        .involved_o  (involved_o)
    );

    trig_history #(.NCH(NCH)) u_hist (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (arm_i),
        .take_i      (take),
        .sample_i    (sample_i),
        .prev_o      (prev),
        .have_prev_o (have_prev)
    );

    trig_arm_ctrl u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .arm_i          (arm_i),
        .sample_valid_i (sample_valid_i),
        .all_met_i      (all_met),
        .cfg_err_i      (cfg_err_o),
        .armed_o        (armed),
        .take_o         (take),
        .hit_o          (hit_o)
    );
endmodule

// File: rtl/trig_match_chk.sv
module trig_match_chk #(
    parameter int NCH = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           arm_i,
    input logic           sample_valid_i,
    input logic [NCH-1:0] trig_en_i,
    input logic [NCH-1:0] lvl_sel_i,
    input logic [NCH-1:0] chan_act_i,
    input logic           armed,
    input logic           hit_o,
    input logic           cfg_err_o,
    input logic           involved_o
);
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        hit_o |=> !hit_o);

    p_err_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        cfg_err_o |=> !hit_o);

    p_err_flag_r5: assert property (@(posedge clk) disable iff (rst)
        cfg_err_o == ($countones(trig_en_i & chan_act_i & ~lvl_sel_i) > 1));

    p_hit_source_r9: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> ($past(sample_valid_i) && !$past(arm_i) && $past(armed)));

    p_disarm_after_hit_r8: assert property (@(posedge clk) disable iff (rst)
        (hit_o && !$past(arm_i) && !arm_i) |=> !armed);

    p_involved_r7: assert property (@(posedge clk) disable iff (rst)
        involved_o == ((trig_en_i & chan_act_i) != '0));
endmodule

bind trig_match_top trig_match_chk #(.NCH(NCH)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .arm_i          (arm_i),
    .sample_valid_i (sample_valid_i),
    .trig_en_i      (trig_en_i),
    .lvl_sel_i      (lvl_sel_i),
    .chan_act_i     (chan_act_i),
    .armed          (armed),
    .hit_o          (hit_o),
    .cfg_err_o      (cfg_err_o),
    .involved_o     (involved_o)
);

// File: tb/trig_match_tb.sv
`timescale 1ns/1ps
module trig_match_top_tb_top;
    localparam int NCH = 16;

    typedef struct packed {
        logic [3:0]  req;
        logic [15:0] en;
        logic [15:0] lvl;
        logic [15:0] pol;
        logic [15:0] act;
        logic [15:0] s0;
        logic [15:0] s1;
        logic        hit0;
        logic        hit1;
        logic        err;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        // R2 low on ch3, fires on first sample; R8 no second hit
        '{4'd2, 16'h0008, 16'h0008, 16'h0000, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0},
        // R2 high on ch3
        '{4'd2, 16'h0008, 16'h0008, 16'h0008, 16'hFFFF, 16'h0000, 16'h0008, 1'b0, 1'b1, 1'b0},
        // R3 rising on ch5
        '{4'd3, 16'h0020, 16'h0000, 16'h0000, 16'hFFFF, 16'h0000, 16'h0020, 1'b0, 1'b1, 1'b0},
        // R6 edge cannot hit on first sample, steady high gives no edge
        '{4'd6, 16'h0020, 16'h0000, 16'h0000, 16'hFFFF, 16'h0020, 16'h0020, 1'b0, 1'b0, 1'b0},
        // R3 falling on ch5
        '{4'd3, 16'h0020, 16'h0000, 16'h0020, 16'hFFFF, 16'h0020, 16'h0000, 1'b0, 1'b1, 1'b0},
        // R4 ch0 high AND ch5 rising, ch0 low blocks
        '{4'd4, 16'h0021, 16'h0001, 16'h0001, 16'hFFFF, 16'h0000, 16'h0020, 1'b0, 1'b0, 1'b0},
        // R4 both met
        '{4'd4, 16'h0021, 16'h0001, 16'h0001, 16'hFFFF, 16'h0001, 16'h0021, 1'b0, 1'b1, 1'b0},
        // R1 junk level/polarity bits on non-enabled channels
        '{4'd1, 16'h0001, 16'hFF01, 16'h0F01, 16'hFFFF, 16'hFFFE, 16'h0001, 1'b0, 1'b1, 1'b0},
        // R1 ch1 inactive, only ch0 high counts
        '{4'd1, 16'h0003, 16'h0003, 16'h0003, 16'h0001, 16'h0001, 16'h0000, 1'b1, 1'b0, 1'b0},
        // R5 two edge channels: error, edge on both gives no hit
        '{4'd5, 16'h0030, 16'h0000, 16'h0000, 16'hFFFF, 16'h0000, 16'h0030, 1'b0, 1'b0, 1'b1},
        // R5 second edge channel inactive: no error, rising on ch4 fires
        '{4'd5, 16'h0030, 16'h0000, 16'h0000, 16'h0010, 16'h0000, 16'h0010, 1'b0, 1'b1, 1'b0},
        // R7 empty enable mask fires on first sample
        '{4'd7, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 16'h1234, 16'h5678, 1'b1, 1'b0, 1'b0}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           arm = 1'b0;
    logic [NCH-1:0] smp = '0;
    logic           vld = 1'b0;
    logic [NCH-1:0] en  = '0;
    logic [NCH-1:0] lvl = '0;
    logic [NCH-1:0] pol = '0;
    logic [NCH-1:0] act = '1;
    logic           hit;
    logic           err;
    logic           inv;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    trig_match_top #(.NCH(NCH)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .arm_i          (arm),
        .sample_i       (smp),
        .sample_valid_i (vld),
        .trig_en_i      (en),
        .lvl_sel_i      (lvl),
        .pol_i          (pol),
        .chan_act_i     (act),
        .hit_o          (hit),
        .cfg_err_o      (err),
        .involved_o     (inv)
    );

    function automatic string rtag(input logic [3:0] r);
        case (r)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            4'd9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic act_v, input logic exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", tag, act_v, exp_v);
        end
    endtask

    task automatic do_arm(input logic with_sample, input logic [NCH-1:0] s);
        @(negedge clk);
        arm = 1'b1;
        vld = with_sample;
        smp = s;
        @(negedge clk);
        arm = 1'b0;
        vld = 1'b0;
    endtask

    // Drives one valid sample; returns after the edge that takes it.
    task automatic send(input logic [NCH-1:0] s);
        @(negedge clk);
        smp = s;
        vld = 1'b1;
        @(negedge clk);
        vld = 1'b0;
    endtask

    task automatic set_cfg(input logic [15:0] e, input logic [15:0] l,
                           input logic [15:0] p, input logic [15:0] a);
        @(negedge clk);
        en = e; lvl = l; pol = p; act = a;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 hit after reset", hit, 1'b0);
        check("R7 involved with empty mask", inv, 1'b0);
        // R10 unarmed: matching sample gives no hit
        set_cfg(16'h0000, 16'h0000, 16'h0000, 16'hFFFF);
        send(16'h0000);
        check("R10 unarmed sample", hit, 1'b0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            set_cfg(VEC[i].en, VEC[i].lvl, VEC[i].pol, VEC[i].act);
            @(negedge clk);
            check($sformatf("%s cfg_err vec %0d", rtag(VEC[i].req), i), err, VEC[i].err);
            check($sformatf("%s involved vec %0d", rtag(VEC[i].req), i), inv, (VEC[i].en & VEC[i].act) != 16'h0);
            do_arm(1'b0, '0);
            send(VEC[i].s0);
            check($sformatf("%s hit s0 vec %0d", rtag(VEC[i].req), i), hit, VEC[i].hit0);
            send(VEC[i].s1);
            check($sformatf("%s hit s1 vec %0d", rtag(VEC[i].req), i), hit, VEC[i].hit1);
        end

        // R8 one-cycle pulse and disarm
        set_cfg(16'h0001, 16'h0001, 16'h0001, 16'hFFFF);
        do_arm(1'b0, '0);
        send(16'h0001);
        check("R8 hit pulse", hit, 1'b1);
        @(negedge clk);
        check("R8 pulse width one cycle", hit, 1'b0);
        send(16'h0001);
        check("R8 no hit after disarm", hit, 1'b0);

        // R9 sample during arm is not history
        set_cfg(16'h0001, 16'h0000, 16'h0000, 16'hFFFF);
        do_arm(1'b1, 16'h0000);
        check("R9 arm cycle sample not evaluated", hit, 1'b0);
        send(16'h0001);
        check("R9 arm cycle sample not history", hit, 1'b0);
        send(16'h0000);
        check("R3 no rise on fall", hit, 1'b0);
        // R3 non-valid cycles between valid samples are skipped
        @(negedge clk);
        smp = 16'h0001;
        repeat (3) @(negedge clk);
        send(16'h0001);
        check("R3 rise across idle gap", hit, 1'b1);

        // R9 arm with sample on empty mask: that sample does not fire
        set_cfg(16'h0000, 16'h0000, 16'h0000, 16'hFFFF);
        do_arm(1'b1, 16'h0000);
        check("R9 empty mask arm cycle", hit, 1'b0);
        send(16'h0000);
        check("R7 first sample after arm", hit, 1'b1);

        // R6 re-arm clears history
        set_cfg(16'h0001, 16'h0000, 16'h0000, 16'hFFFF);
        do_arm(1'b0, '0);
        send(16'h0000);
        do_arm(1'b0, '0);
        send(16'h0001);
        check("R6 re-arm clears history", hit, 1'b0);

        // R10 reset while armed clears the arming
        do_arm(1'b0, '0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        set_cfg(16'h0000, 16'h0000, 16'h0000, 16'hFFFF);
        send(16'h0000);
        check("R10 reset disarms", hit, 1'b0);

        finish_run();
    end
endmodule